// File: doc/BRIEF.md
# Delay-Lock Loop Search-and-Track Controller

This block is the digital control logic of a delay-locked loop. Once per reference clock cycle it reads a one-bit decision from the phase detector, `pd_short`. A 1 on this input means the replica delay is still too short and needs more delay. The block drives a 10-bit delay code to the delay line, split into two parts: a binary coarse field (code bits 9..4) and a thermometer-coded fine field. The fine field drives 15 enable lines, and each fine step turns on exactly one more unit cell.

After reset, or after a `start` pulse, the controller runs a successive-approximation search. It starts at mid-scale, trial-sets each code bit from the most significant to the least significant, and keeps or clears that bit according to the detector. The four coarse high bits each get an extra settle cycle before their decision, because their delay steps are large. The six low bits are decided in consecutive cycles. When the search ends, `locked` rises and the controller enters tracking. In tracking it moves the code by one LSB whenever two consecutive decisions agree, and it saturates at both ends of the code range.

The states are `ACQ_SETTLE`, `ACQ_DECIDE` and `TRK_FOLLOW`:

- Reset or `start` sends the controller to `ACQ_SETTLE` with the MSB under trial.
- `ACQ_SETTLE` always moves to `ACQ_DECIDE`.
- `ACQ_DECIDE` moves to `ACQ_SETTLE` when the next bit is one of the four slow bits.
- `ACQ_DECIDE` stays in `ACQ_DECIDE` when the next bit is a fast bit.
- `ACQ_DECIDE` moves to `TRK_FOLLOW` after bit 0 is decided.
- `TRK_FOLLOW` stays in `TRK_FOLLOW` until reset or `start`.

Top module: `dll_sar_ctrl`

## Requirements
- R1: A synchronous `rst` or `start` puts the code at mid-scale 10'h200 (coarse_code = 32, fine_therm = 0) in the following cycle, clears `locked` and restarts the search.
- R2: `coarse_code` equals code bits 9..4, and `fine_therm[k]` is 1 exactly when code bits 3..0, read as an unsigned number, exceed k (k = 0..14).
- R3: The search trial-sets each bit from bit 9 down to bit 0 and keeps that bit only when `pd_short` = 1 in its decision cycle. With a detector that reports 1 exactly when the code is below a target T, the acquired code is T-1 (0 when T = 0, 10'h3FF when T > 1023).
- R4: Bits 9..6 take a settle cycle and then a decision cycle, and bits 5..0 take one decision cycle each. `locked` therefore rises exactly 14 cycles after reset or `start` is released, which is within the 18-cycle limit.
- R5: Once `locked` is 1, it stays at 1 until `rst` or `start`.
- R6: In tracking, two consecutive equal decisions move the code by one LSB: up for 1, down for 0. The agreement count then starts over, so decisions that alternate every cycle leave the code unchanged.
- R7: Tracking steps carry from the fine field into the coarse field and borrow back from it (10'h01F to 10'h020 and back).
- R8: In tracking, the code holds at 10'h3FF under further up decisions and at 10'h000 under further down decisions, without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Synchronous restart of acquisition, active high |
| pd_short | input | 1 | Phase decision: 1 = delay too short, 0 = delay too long |
| coarse_code | output | 6 | Binary coarse delay select |
| fine_therm | output | 15 | Thermometer enables for the fine delay cells |
| locked | output | 1 | Acquisition finished; tracking active |

## Verification
The assertions assume two things about the inputs. First, `pd_short` is valid and stable around every reference edge. Second, the detector is monotonic in the code during a search, so the binary search converges. The bench derives `pd_short` from a behavioural model: the code is compared with a target delay, and the code is rebuilt from the coarse field and the count of ones in the thermometer field. The target changes only at points where the bench expects it to. The bench forces an alternating detector pattern only in the dither test, and only after tracking has started.

// File: rtl/dll_sar_pkg.sv
package dll_sar_pkg;
    typedef enum logic [1:0] {
        ACQ_SETTLE = 2'd0,
        ACQ_DECIDE = 2'd1,
        TRK_FOLLOW = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/dll_therm_enc.sv
module dll_therm_enc #(
    parameter int BIN_W = 4,
    parameter int OUT_W = (1 << BIN_W) - 1
) (
    input  logic [BIN_W-1:0] bin,
    output logic [OUT_W-1:0] therm
);
    for (genvar k = 0; k < OUT_W; k++) begin : g_cell
        assign therm[k] = (bin > BIN_W'(k));
    end

    // R2
    always_comb begin
        therm_count_chk: assert ($isunknown(bin) || $countones(therm) == int'(bin));
    end
endmodule

// File: rtl/dll_track_filter.sv
module dll_track_filter #(
    parameter int AGREE = 2,
    parameter int CNT_W = $clog2(AGREE + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pd_short,
    output logic step_up,
    output logic step_dn
);
    logic             last_q;
    logic [CNT_W-1:0] run_q;
    logic             same;
    logic             fire;

    assign same    = (run_q != '0) && (pd_short == last_q);
    assign fire    = en && same && (run_q == CNT_W'(AGREE - 1));
    assign step_up = fire & pd_short;
    assign step_dn = fire & ~pd_short;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (fire) begin
            run_q  <= '0;
        end else if (same) begin
            run_q  <= run_q + 1'b1;
        end else begin
            last_q <= pd_short;
            run_q  <= CNT_W'(1);
        end
    end

    // R6
    step_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |-> ($past(en) && $past(pd_short) == pd_short));
endmodule

// File: rtl/dll_sar_ctrl.sv
module dll_sar_ctrl
    import dll_sar_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int FINE_W      = 4,
    parameter int SETTLE_BITS = 4,
    parameter int AGREE       = 2,
    parameter int LOCK_LIMIT  = 18
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic                           pd_short,
    output logic [CODE_W-FINE_W-1:0]       coarse_code,
    output logic [(1 << FINE_W)-2:0]       fine_therm,
    output logic                           locked
);
    localparam int COARSE_W = CODE_W - FINE_W;
    localparam int THERM_W  = (1 << FINE_W) - 1;
    localparam int IDX_W    = $clog2(CODE_W);
    localparam int SLOW_LO  = CODE_W - SETTLE_BITS;
    localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] MAX_CODE = '1;
    localparam logic [IDX_W-1:0]  TOP_IDX  = IDX_W'(CODE_W - 1);
    localparam int ACNT_W   = $clog2(LOCK_LIMIT + 2);

    ctl_state_t        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [IDX_W-1:0]  bit_q, bit_d;
    logic              locked_q, locked_d;
    logic              step_up, step_dn;
    logic              trk_en;

    assign trk_en = (state_q == TRK_FOLLOW) && !start;

    dll_track_filter #(.AGREE(AGREE)) u_filter (
        .clk      (clk),
        .rst      (rst),
        .en       (trk_en),
        .pd_short (pd_short),
        .step_up  (step_up),
        .step_dn  (step_dn)
    );

    always_comb begin
        state_d  = state_q;
        code_d   = code_q;
        bit_d    = bit_q;
        locked_d = locked_q;
        if (rst || start) begin
            state_d  = (CODE_W - 1 >= SLOW_LO) ? ACQ_SETTLE : ACQ_DECIDE;
            code_d   = MID_CODE;
            bit_d    = TOP_IDX;
            locked_d = 1'b0;
        end else begin
            unique case (state_q)
                ACQ_SETTLE: state_d = ACQ_DECIDE;
                ACQ_DECIDE: begin
                    if (!pd_short) code_d[bit_q] = 1'b0;
                    if (bit_q == '0) begin
                        state_d  = TRK_FOLLOW;
                        locked_d = 1'b1;
                    end else begin
                        code_d[bit_q - 1'b1] = 1'b1;
                        bit_d   = bit_q - 1'b1;
                        state_d = (int'(bit_q) - 1 >= SLOW_LO) ? ACQ_SETTLE : ACQ_DECIDE;
                    end
                end
                TRK_FOLLOW: begin
                    if (step_up && code_q != MAX_CODE)  code_d = code_q + 1'b1;
                    else if (step_dn && code_q != '0)   code_d = code_q - 1'b1;
                end
                default: state_d = ACQ_SETTLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        state_q  <= state_d;
        code_q   <= code_d;
        bit_q    <= bit_d;
        locked_q <= locked_d;
    end

    assign coarse_code = code_q[CODE_W-1 -: COARSE_W];
    assign locked      = locked_q;

    dll_therm_enc #(.BIN_W(FINE_W), .OUT_W(THERM_W)) u_therm (
        .bin   (code_q[FINE_W-1:0]),
        .therm (fine_therm)
    );

    logic [ACNT_W-1:0] acq_cnt;
    always_ff @(posedge clk) begin
        if (rst || start)                              acq_cnt <= '0;
        else if (!locked_q && acq_cnt != '1)           acq_cnt <= acq_cnt + 1'b1;
    end

    // R1
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (code_q == MID_CODE && !locked_q));
    // R4
    lock_time_chk: assert property (@(posedge clk) disable iff (rst || start)
        !locked_q |-> (int'(acq_cnt) < LOCK_LIMIT));
    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (locked_q && !start) |=> locked_q);
    // R6 R7
    track_step_chk: assert property (@(posedge clk) disable iff (rst || start)
        (state_q == TRK_FOLLOW && $past(state_q) == TRK_FOLLOW) |->
        (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1 ||
         code_q == $past(code_q) - 1'b1));
    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TRK_FOLLOW && !start && code_q == MAX_CODE) |=> code_q != '0);
endmodule

// File: tb/dll_sar_ctrl_bench.sv
module dll_sar_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pd_short;
    logic [5:0]  coarse_code;
    logic [14:0] fine_therm;
    logic        locked;

    int  n_chk = 0;
    int  n_bad = 0;
    int  target = 0;
    logic force_en = 1'b0;
    logic force_val = 1'b0;
    int  code_now;

    always #10 clk = ~clk;

    always_comb code_now = int'(coarse_code) * 16 + $countones(fine_therm);
    assign pd_short = force_en ? force_val : (code_now < target);

    dll_sar_ctrl u_dll_sar_ctrl (
        .clk(clk), .rst(rst), .start(start), .pd_short(pd_short),
        .coarse_code(coarse_code), .fine_therm(fine_therm), .locked(locked)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acquire(input int tgt, input string req);
        int n = 0;
        target = tgt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1 mid-scale after start", code_now, 512);
        check("R1 locked clear after start", int'(locked), 0);
        while (!locked && n < 30) begin
            @(negedge clk);
            n++;
        end
        check("R4 lock latency", n, 13 + 1);
        check({req, " acquired code"}, code_now, tgt == 0 ? 0 : (tgt > 1023 ? 1023 : tgt - 1));
    endtask

    task automatic t_reset();
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1 reset code", code_now, 512);
        check("R1 reset coarse", int'(coarse_code), 32);
        check("R2 reset therm", int'(fine_therm), 0);
        check("R1 reset locked", int'(locked), 0);
        rst = 1'b0;
    endtask

    task automatic t_acq_patterns();
        acquire(300, "R3");
        acquire(777, "R3");
        acquire(1, "R3");
        check("R2 coarse field", int'(coarse_code), 0);
    endtask

    task automatic t_track_follow();
        acquire(400, "R3");
        target = 405;
        repeat (24) @(negedge clk);
        check("R6 follows drift", int'(code_now == 404 || code_now == 405), 1);
        check("R5 locked held", int'(locked), 1);
    endtask

    task automatic t_dither();
        int held;
        int moved = 0;
        acquire(600, "R3");
        force_en = 1'b1;
        force_val = 1'b1;
        @(negedge clk);
        held = code_now;
        for (int i = 0; i < 20; i++) begin
            force_val = ~force_val;
            @(negedge clk);
            if (code_now != held) moved++;
        end
        force_en = 1'b0;
        check("R6 alternating decisions ignored", moved, 0);
    endtask

    task automatic t_carry();
        int saw_up = 0;
        int saw_dn = 0;
        acquire(32, "R3");
        check("R2 therm full at 0x1F", int'(fine_therm), 32767);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (coarse_code == 6'd2 && fine_therm == 15'd0) saw_up = 1;
            if (saw_up == 1 && coarse_code == 6'd1 && fine_therm == 15'h7FFF) saw_dn = 1;
        end
        check("R7 carry into coarse", saw_up, 1);
        check("R7 borrow from coarse", saw_dn, 1);
    endtask

    task automatic t_saturate();
        acquire(2000, "R3 top");
        repeat (10) @(negedge clk);
        check("R8 hold at all-ones", code_now, 1023);
        check("R2 coarse all-ones", int'(coarse_code), 63);
        acquire(0, "R3 bottom");
        repeat (10) @(negedge clk);
        check("R8 hold at zero", code_now, 0);
    endtask

    task automatic t_restart();
        acquire(250, "R3");
        repeat (5) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1 restart code", code_now, 512);
        check("R1 restart locked", int'(locked), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_acq_patterns();
        t_track_follow();
        t_dither();
        t_carry();
        t_saturate();
        t_restart();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule